// File: doc/BRIEF.md
# PLL Reference Divider and Lock Timer

This block is the digital control shell placed beside a frequency-multiplying PLL. A single configuration write loads three fields together: an integer reference divide value, a multiply value and a lock wait count. The divider turns the main clock into the PLL reference, and a zero divide value stops that reference at logic 0. The multiply field goes to the analog core as the field value plus one. A zero multiply value powers the core down. The output frequency therefore scales by (multiply + 1) / divide.

Every configuration write starts the lock check again. The lock flag drops at once. The wait count is loaded into a down-counter, and that counter steps on rising edges of a slow clock, which is synchronized into the main clock domain. When the count runs out, the lock flag rises. If interrupts are enabled, a one-cycle interrupt request fires at the same time. A separate mode write chooses whether the PLL output clock is halved before it leaves the block, and whether lock interrupts are enabled. A mode write does not disturb the lock timer.

Top module: `pll_ref_lock_ctrl`

## Requirements
- R1: After reset, ref_clk_o, pll_clk_o, pll_en_o, lock_o and irq_o are all 0, and the divide field reads as 0.
- R2: With a divide value N from 1 to 255, ref_clk_o is periodic with a period of exactly N main-clock cycles. N = 1 passes the main clock through.
- R3: With a divide value of 0, ref_clk_o and pll_clk_o both stay at a constant 0.
- R4: After a configuration write, pll_mul_o equals the multiply field plus one (width MUL_W+1), and pll_en_o is 1 exactly when the multiply field is nonzero.
- R5: Any configuration write clears lock_o on the clock edge that captures it.
- R6: With a nonzero multiply value and a wait count K of 1 or more, lock_o rises after the K-th synchronized slow-clock rising edge and not before. K = 0 behaves like K = 1.
- R7: With a multiply value of 0, lock_o stays 0 however many slow-clock edges arrive.
- R8: lock_o is a level that holds until the next configuration write. irq_o is a single-cycle pulse on the edge where lock_o rises, and it occurs only when the interrupt-enable mode bit is 1.
- R9: With the halve mode bit at 1, pll_clk_o is pll_core_clk_i divided by two. With it at 0, pll_clk_o follows pll_core_clk_i. Either way the divide and multiply values must both be nonzero for pll_clk_o to run.
- R10: A mode write changes neither lock_o nor the state of the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | Slow clock that paces the lock countdown, asynchronous to clk_i |
| pll_core_clk_i | input | 1 | Output clock from the analog PLL core |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_div_i | input | DIV_W | Reference divide value, 0 stops the reference |
| cfg_mul_i | input | MUL_W | Multiply value, 0 disables the PLL |
| cfg_cnt_i | input | CNT_W | Lock wait count, in slow-clock edges |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_half_i | input | 1 | Halve the PLL output clock |
| mode_irq_en_i | input | 1 | Enable the lock interrupt request |
| ref_clk_o | output | 1 | Divided reference clock to the PLL |
| pll_en_o | output | 1 | PLL core enable |
| pll_mul_o | output | MUL_W+1 | Multiply factor driven to the PLL core |
| pll_clk_o | output | 1 | Gated and optionally halved PLL clock |
| lock_o | output | 1 | Lock status level |
| irq_o | output | 1 | One-cycle lock interrupt request |

## Verification
The hardest situations to reach are those that depend on where the lock countdown stands when a slow-clock edge arrives, relative to the writes around it. Examples are the exact edge on which lock_o rises, a mode write arriving while the block is locked, and a countdown that is disabled by a zero multiply value. The bench drives the slow clock itself, as discrete, widely spaced pulses. Because each pulse lets exactly one synchronized edge through, lock_o and irq_o can be checked after a known number of pulses, one pulse before the expected point and again at it.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
   typedef enum logic [1:0] {
      LK_IDLE   = 2'd0,
      LK_COUNT  = 2'd1,
      LK_LOCKED = 2'd2
   } lock_state_e;
endpackage

// File: rtl/pll_tick_sync.sv
module pll_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic tick_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pll_tick_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[s] <= 1'b0;
         else if (s == 0) chain_q[s] <= async_i;
         else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else last_q <= chain_q[STAGES-1];
   end

   assign tick_o = chain_q[STAGES-1] & ~last_q;

   // R6: one decrement enable per slow edge
   p_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             ref_o
);
   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
      $error("pll_ref_div: DIV_W must lie in 2..16");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             ref_q;
   logic [DIV_W-1:0] half_w;
   logic             pass_w;

   assign half_w = div_q >> 1;
   assign pass_w = (div_q == DIV_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else if (load_i) begin
         div_q <= div_i;
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else if (div_q > DIV_W'(1)) begin
         cnt_q <= (cnt_q == div_q - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
         ref_q <= (cnt_q < half_w);
      end else begin
         ref_q <= 1'b0;
      end
   end

   assign ref_o = pass_w ? clk_i : ref_q;

   // R3: a stopped divider keeps its registered output low
   p_ref_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q == '0) |-> !ref_q);
   // R2: the phase counter never leaves its range
   p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q > DIV_W'(1)) |-> (cnt_q < div_q));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
   import pll_lock_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             tick_i,
   input  logic             irq_en_i,
   output logic             lock_o,
   output logic             irq_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pll_lock_timer: CNT_W must be positive");
   end

   lock_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             expire_w;

   assign expire_w = (state_q == LK_COUNT) && tick_i && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LK_IDLE;
         cnt_q   <= '0;
         irq_q   <= 1'b0;
      end else if (restart_i) begin
         state_q <= enable_i ? LK_COUNT : LK_IDLE;
         cnt_q   <= count_i;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= expire_w & irq_en_i;
         if (expire_w) state_q <= LK_LOCKED;
         else if (state_q == LK_COUNT && tick_i) cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign lock_o = (state_q == LK_LOCKED);
   assign irq_o  = irq_q;

   // R5: a restart drops the lock flag at once
   p_restart_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> !lock_o);
   // R8: the request lasts one cycle only
   p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);
   // R8: the request marks the rise of the lock flag
   p_irq_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (lock_o && !$past(lock_o)));
   // R6: the lock flag rises only on a slow-clock edge
   p_lock_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_o) |-> $past(tick_i));
endmodule

// File: rtl/pll_ref_lock_ctrl.sv
module pll_ref_lock_ctrl #(
   parameter int DIV_W       = 8,
   parameter int MUL_W       = 11,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit HALF_EN     = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             slow_clk_i,
   input  logic             pll_core_clk_i,
   input  logic             cfg_wr_i,
   input  logic [DIV_W-1:0] cfg_div_i,
   input  logic [MUL_W-1:0] cfg_mul_i,
   input  logic [CNT_W-1:0] cfg_cnt_i,
   input  logic             mode_wr_i,
   input  logic             mode_half_i,
   input  logic             mode_irq_en_i,
   output logic             ref_clk_o,
   output logic             pll_en_o,
   output logic [MUL_W:0]   pll_mul_o,
   output logic             pll_clk_o,
   output logic             lock_o,
   output logic             irq_o
);
   localparam int MUL_OUT_W = MUL_W + 1;

   if (MUL_W < 1 || MUL_W > 24) begin : g_bad_mul
      $error("pll_ref_lock_ctrl: MUL_W must lie in 1..24");
   end

   logic [MUL_W-1:0] mul_q;
   logic             gate_q;
   logic             half_q;
   logic             irq_en_q;
   logic             tick_w;
   logic             core_sel_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mul_q  <= '0;
         gate_q <= 1'b0;
      end else if (cfg_wr_i) begin
         mul_q  <= cfg_mul_i;
         gate_q <= (cfg_mul_i != '0) && (cfg_div_i != '0);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_q   <= 1'b0;
         irq_en_q <= 1'b0;
      end else if (mode_wr_i) begin
         half_q   <= mode_half_i & HALF_EN;
         irq_en_q <= mode_irq_en_i;
      end
   end

   assign pll_en_o  = (mul_q != '0);
   assign pll_mul_o = MUL_OUT_W'(mul_q) + MUL_OUT_W'(1);

   pll_ref_div #(.DIV_W(DIV_W)) i_ref_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cfg_wr_i),
      .div_i  (cfg_div_i),
      .ref_o  (ref_clk_o)
   );

   pll_tick_sync #(.STAGES(SYNC_STAGES)) i_tick_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (slow_clk_i),
      .tick_o  (tick_w)
   );

   pll_lock_timer #(.CNT_W(CNT_W)) i_lock_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (cfg_wr_i),
      .enable_i  (cfg_mul_i != '0),
      .count_i   (cfg_cnt_i),
      .tick_i    (tick_w),
      .irq_en_i  (irq_en_q),
      .lock_o    (lock_o),
      .irq_o     (irq_o)
   );

   if (HALF_EN) begin : g_halver
      logic div2_q;
      always_ff @(posedge pll_core_clk_i or negedge rst_ni) begin
         if (!rst_ni) div2_q <= 1'b0;
         else div2_q <= ~div2_q;
      end
      assign core_sel_w = half_q ? div2_q : pll_core_clk_i;
   end else begin : g_no_halver
      assign core_sel_w = pll_core_clk_i;
   end

   assign pll_clk_o = gate_q & core_sel_w;

   // R7: lock is only reported while the PLL runs
   p_lock_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_o |-> pll_en_o);
   // R4: the multiply output tracks the written field plus one
   p_mul_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wr_i |=> (pll_mul_o == MUL_OUT_W'($past(cfg_mul_i)) + MUL_OUT_W'(1)));
   // R10: a lone mode write keeps the lock flag
   p_mode_keeps_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_wr_i && !cfg_wr_i && lock_o) |=> lock_o);
endmodule

// File: tb/test_pll_ref_lock_ctrl.sv
module test_pll_ref_lock_ctrl;
   localparam int CLK_PER  = 10;
   localparam int CORE_PER = 6;
   localparam int NV       = 5;
   localparam int VEC_DIV  [NV] = '{1, 2, 3, 7, 255};
   localparam int VEC_MUL  [NV] = '{0, 1, 39, 100, 2047};
   localparam int VEC_PER  [NV] = '{1, 2, 3, 7, 255};
   localparam int VEC_MULO [NV] = '{1, 2, 40, 101, 2048};
   localparam int VEC_EN   [NV] = '{0, 1, 1, 1, 1};

   logic        clk = 1'b0, core_clk = 1'b0, rst_n = 1'b0, slow = 1'b0;
   logic        cfg_wr = 1'b0, mode_wr = 1'b0, mode_half = 1'b0, mode_irq = 1'b0;
   logic [7:0]  cfg_div = '0;
   logic [10:0] cfg_mul = '0;
   logic [5:0]  cfg_cnt = '0;
   logic        ref_clk, pll_en, pll_clk, lock, irq;
   logic [11:0] pll_mul;

   int tests = 0, fails = 0, irq_count = 0, irq_run = 0, irq_max = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;
   always #(CORE_PER/2) core_clk = ~core_clk;

   pll_ref_lock_ctrl i_pll_ref_lock_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow), .pll_core_clk_i(core_clk),
      .cfg_wr_i(cfg_wr), .cfg_div_i(cfg_div), .cfg_mul_i(cfg_mul), .cfg_cnt_i(cfg_cnt),
      .mode_wr_i(mode_wr), .mode_half_i(mode_half), .mode_irq_en_i(mode_irq),
      .ref_clk_o(ref_clk), .pll_en_o(pll_en), .pll_mul_o(pll_mul),
      .pll_clk_o(pll_clk), .lock_o(lock), .irq_o(irq));

   always @(posedge clk) begin
      if (irq) begin
         irq_count <= irq_count + 1;
         irq_run   <= irq_run + 1;
         if (irq_run + 1 > irq_max) irq_max <= irq_run + 1;
      end else irq_run <= 0;
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int d, input int m, input int c);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_div = 8'(d); cfg_mul = 11'(m); cfg_cnt = 6'(c);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic mode(input bit h, input bit ie);
      @(negedge clk);
      mode_wr = 1'b1; mode_half = h; mode_irq = ie;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic slow_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         repeat (4) @(negedge clk);
         slow = 1'b1;
         repeat (4) @(negedge clk);
         slow = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic ref_period(output int per);
      time t0;
      @(posedge ref_clk); t0 = $time;
      @(posedge ref_clk); per = int'(($time - t0) / CLK_PER);
   endtask

   task automatic core_period(output int per);
      time t0;
      @(posedge pll_clk); t0 = $time;
      @(posedge pll_clk); per = int'($time - t0);
   endtask

   initial begin
      #(CLK_PER * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int per, hi, irq0;
      repeat (3) @(negedge clk);
      // R1 reset state, sampled while reset is held and after release
      check("R1 ref", int'(ref_clk), 0);
      check("R1 pll_en", int'(pll_en), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 pll_clk", int'(pll_clk), 0);
      check("R1 lock", int'(lock), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 mul", int'(pll_mul), 1);

      // R2 and R4 across the vector table
      for (int v = 0; v < NV; v++) begin
         cfg(VEC_DIV[v], VEC_MUL[v], 3);
         check("R4 mul", int'(pll_mul), VEC_MULO[v]);
         check("R4 en", int'(pll_en), VEC_EN[v]);
         repeat (2) @(negedge clk);
         ref_period(per);
         check("R2 period", per, VEC_PER[v]);
      end

      // R3: divide value zero stops both clocks
      cfg(0, 5, 3);
      hi = 0;
      for (int i = 0; i < 60; i++) begin
         #(CLK_PER/5);
         if (ref_clk || pll_clk) hi++;
      end
      check("R3 stopped clocks", hi, 0);

      // R6/R8: count of 3, interrupts on
      mode(1'b0, 1'b1);
      cfg(4, 10, 3);
      check("R5 cleared", int'(lock), 0);
      slow_pulses(2);
      check("R6 before count", int'(lock), 0);
      irq0 = irq_count;
      slow_pulses(1);
      check("R6 at count", int'(lock), 1);
      check("R8 one irq", irq_count - irq0, 1);
      check("R8 irq width", irq_max, 1);
      slow_pulses(2);
      check("R8 level held", int'(lock), 1);
      check("R8 no extra irq", irq_count - irq0, 1);

      // R10 mode write while locked
      mode(1'b0, 1'b1);
      check("R10 lock kept", int'(lock), 1);

      // R5 write clears lock
      cfg(4, 10, 2);
      check("R5 cleared by write", int'(lock), 0);
      mode(1'b0, 1'b1);
      slow_pulses(1);
      check("R10 countdown intact", int'(lock), 0);
      slow_pulses(1);
      check("R10 lock after count", int'(lock), 1);

      // R6 zero count acts as one
      cfg(4, 10, 0);
      check("R6 zero count cleared", int'(lock), 0);
      slow_pulses(1);
      check("R6 zero count", int'(lock), 1);

      // R7 disabled PLL never locks
      cfg(4, 0, 1);
      slow_pulses(3);
      check("R7 no lock", int'(lock), 0);
      check("R7 en", int'(pll_en), 0);

      // R8 interrupt disabled
      mode(1'b0, 1'b0);
      cfg(4, 10, 1);
      irq0 = irq_count;
      slow_pulses(1);
      check("R8 lock irq off", int'(lock), 1);
      check("R8 no irq when off", irq_count - irq0, 0);

      // R9 halve option
      cfg(2, 10, 1);
      repeat (2) @(negedge clk);
      core_period(per);
      check("R9 direct period", per, CORE_PER);
      mode(1'b1, 1'b0);
      repeat (2) @(negedge clk);
      core_period(per);
      check("R9 halved period", per, 2 * CORE_PER);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule